// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves blocks of data on behalf of a processor over a single-master bus. It has two independent channels. Each holds a source address, a destination address, a transfer count and a control word, all written and read through a small register port. A channel copies one unit at a time. It reads the unit from the source into an internal holding register and then writes it to the destination. The unit can be a byte, a half-word or a word. Either address can advance with each unit (memory) or stay put (an I/O port), so each channel can copy memory to memory, I/O to memory or I/O to I/O.

When both channels want the bus, an arbiter picks one. A mode pin selects either fixed order or rotation. Each channel either gives up the bus after every unit (cycle steal) or keeps it until its block is finished (burst). A channel is started by software through its control word. It can also be set to move units only while its own external request line is high. When a block finishes, or when a transfer fails, the channel sets a status bit and can raise its own interrupt line.

Register map: address bit 2 selects the channel, and bits 1:0 select the register. The registers are 0 source, 1 destination, 2 count and 3 control/status.

Top module: `dma2_top`

## Requirements
- R1: After reset, bus_req and irq are low and all eight registers read as zero.
- R2: A started channel reads each unit from the source address and writes the same data to the destination address. Control bits 3:2 select the unit size: 0 byte, 1 half-word, 2 word. A moving address advances by 1, 2 or 4 after each unit. The count register reads the number of units still to move, and reads 0 at the end.
- R3: Control bit 4 holds the source address fixed and control bit 5 holds the destination address fixed. A fixed address reads back unchanged after the block.
- R4: A count of 0 at start means 65,536 units, so after the first unit the count register reads 0xFFFF or slightly less.
- R5: When rr_mode is low and both channels request in the same cycle, channel 0 is served, and it keeps winning until its block ends.
- R6: When rr_mode is high and both channels request, the channel served last becomes the lower priority, so the two channels alternate one unit at a time.
- R7: With control bit 6 clear (cycle steal), bus_req falls after every unit, so a block of N units gives N falling edges.
- R8: With control bit 6 set (burst), bus_req stays high from the first unit to the last, giving one falling edge per block.
- R9: With control bit 7 set, a started channel moves units only while its ext_req input is high. With ext_req low, no bus request is raised.
- R10: When a block ends, control bit 16 (done) is set. irq for that channel goes high only if control bit 8 (interrupt enable) is set. Writing 1 to bit 16 clears the bit and the interrupt.
- R11: An error response on either the read or the write stops the channel without counting that unit. It sets control bit 17 (error) and raises irq if enabled. Writing 1 to bit 17 clears it.
- R12: Setting control bit 0 (start) with size code 3, or with a source or destination address that is not a multiple of the unit size, sets the error bit instead of starting. No bus request follows.
- R13: Writing control bit 1 (abort) stops an active channel after the unit in flight, without setting done. Control bit 0 reads whether the channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 1 selects rotating priority, 0 fixed (channel 0 first) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bit 2 channel, bits 1:0 register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ext_req | input | 2 | External transfer request, one per channel |
| irq | output | 2 | Interrupt, one per channel |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | Bus access valid |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Unit size code of the access |
| bus_wdata | output | 32 | Write data, unit in the low bits |
| bus_ready | input | 1 | Access finished this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_err | input | 1 | Error response, valid with bus_ready |

## Verification
A register write takes effect at the next clock edge, and a register read reflects state in the same cycle. The bench therefore writes on one falling edge and reads one cycle later. bus_req rises one cycle after a channel starts requesting. Each unit then takes the grant delay plus one ready per access, and the duration depends on the slave model. For that reason the bench does not wait a fixed number of cycles. It polls the status bits with a bounded timeout, and it counts bus_req edges and completed writes in a monitor that samples on the clock. It reads all results half a cycle away from the active edge. Checks that something did not happen, such as no bus activity before ext_req rises or after an abort, wait a fixed number of idle cycles and compare the monitor counts.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
    localparam int NCH   = 2;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_BAD = 2'd3} unit_e;

    typedef struct packed {
        logic  irq_en;
        logic  ext_trig;
        logic  burst;
        logic  dst_hold;
        logic  src_hold;
        unit_e size;
    } chan_cfg_t;

    typedef enum logic [1:0] {EN_IDLE, EN_GRANT, EN_READ, EN_WRITE} eng_state_e;

    typedef struct packed {
        eng_state_e        state;
        logic              ch;
        logic              last;
        logic [BUS_W-1:0]  hold;
    } eng_t;
endpackage

// File: rtl/dma2_arb.sv
module dma2_arb (
    input  logic [1:0] req,
    input  logic       rr_mode,
    input  logic       last,
    output logic       any,
    output logic       pick
);
    always_comb begin
        any  = |req;
        pick = (&req) ? (rr_mode & ~last) : req[1];
    end
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              ext_req,
    input  logic              beat_done,
    input  logic              fail,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output chan_cfg_t         cfg,
    output logic              active,
    output logic              req,
    output logic              last_beat,
    output logic              irq
);
    localparam int REM_W = CNT_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [REM_W-1:0]  rem;
        chan_cfg_t         cfg;
        logic              active;
        logic              done;
        logic              err;
    } chan_t;

    chan_t q, d;

    function automatic logic misaligned(input logic [ADDR_W-1:0] a, input unit_e s);
        case (s)
            SZ_HALF: misaligned = a[0];
            SZ_WORD: misaligned = |a[1:0];
            default: misaligned = 1'b0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] step_of(input unit_e s);
        case (s)
            SZ_HALF: step_of = ADDR_W'(2);
            SZ_WORD: step_of = ADDR_W'(4);
            default: step_of = ADDR_W'(1);
        endcase
    endfunction

    unit_e new_size;
    logic  bad_start;

    always_comb begin
        new_size  = unit_e'(wr_data[3:2]);
        bad_start = (new_size == SZ_BAD) || misaligned(q.src, new_size) || misaligned(q.dst, new_size);
        d = q;
        if (beat_done) begin
            if (!q.cfg.src_hold) d.src = q.src + step_of(q.cfg.size);
            if (!q.cfg.dst_hold) d.dst = q.dst + step_of(q.cfg.size);
            d.rem = q.rem - REM_W'(1);
            if (q.rem == REM_W'(1)) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end
        if (fail) begin
            d.active = 1'b0;
            d.err    = 1'b1;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: d.src = wr_data[ADDR_W-1:0];
                2'd1: d.dst = wr_data[ADDR_W-1:0];
                2'd2: d.rem = {1'b0, wr_data[CNT_W-1:0]};
                default: begin
                    d.cfg = chan_cfg_t'(wr_data[8:2]);
                    if (wr_data[16]) d.done = 1'b0;
                    if (wr_data[17]) d.err  = 1'b0;
                    if (wr_data[1]) begin
                        d.active = 1'b0;
                    end else if (wr_data[0] && !q.active) begin
                        if (bad_start) begin
                            d.err = 1'b1;
                        end else begin
                            d.active = 1'b1;
                            if (q.rem == '0) d.rem = REM_W'(1) << CNT_W;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        src_addr  = q.src;
        dst_addr  = q.dst;
        cfg       = q.cfg;
        active    = q.active;
        req       = q.active && (!q.cfg.ext_trig || ext_req);
        last_beat = (q.rem == REM_W'(1));
        irq       = q.cfg.irq_en && (q.done || q.err);
        case (rd_sel)
            2'd0:    rd_data = 32'(q.src);
            2'd1:    rd_data = 32'(q.dst);
            2'd2:    rd_data = 32'(q.rem[CNT_W-1:0]);
            default: rd_data = {14'd0, q.err, q.done, 7'd0, q.cfg, 1'b0, q.active};
        endcase
    end

    // R10: the final unit ends the block and sets done
    a_r10_final_unit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && q.rem == REM_W'(1) && !fail && !wr_en) |=> (!q.active && q.done));

    // R11: an error response stops the channel and records it
    a_r11_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !wr_en) |=> (q.err && !q.active));

    // R12: a start with the reserved size code never activates the channel
    a_r12_bad_size_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && wr_data[0] && !wr_data[1] && wr_data[3:2] == 2'd3 && !q.active)
        |=> (q.err && !q.active));
endmodule

// File: rtl/dma2_top.sv
module dma2_top
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rr_mode,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        ext_req,
    output logic [1:0]        irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_ready,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_err
);
    logic [ADDR_W-1:0] src_a [NCH];
    logic [ADDR_W-1:0] dst_a [NCH];
    chan_cfg_t         cfg_a [NCH];
    logic [31:0]       rd_a  [NCH];
    logic [NCH-1:0]    act, creq, lastb, beat, failv;
    logic              arb_any, arb_pick;

    eng_t q, d;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign beat[i]  = (q.state == EN_WRITE) && bus_ready && !bus_err && (q.ch == 1'(i));
        assign failv[i] = ((q.state == EN_READ) || (q.state == EN_WRITE)) && bus_ready && bus_err
                          && (q.ch == 1'(i));
        dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_we && (reg_addr[2] == 1'(i))), .wr_sel(reg_addr[1:0]), .wr_data(reg_wdata),
            .rd_sel(reg_addr[1:0]), .rd_data(rd_a[i]),
            .ext_req(ext_req[i]), .beat_done(beat[i]), .fail(failv[i]),
            .src_addr(src_a[i]), .dst_addr(dst_a[i]), .cfg(cfg_a[i]),
            .active(act[i]), .req(creq[i]), .last_beat(lastb[i]), .irq(irq[i])
        );
    end

    dma2_arb u_arb (.req(creq), .rr_mode(rr_mode), .last(q.last), .any(arb_any), .pick(arb_pick));

    always_comb begin
        d = q;
        case (q.state)
            EN_IDLE: if (arb_any) begin
                d.ch    = arb_pick;
                d.state = EN_GRANT;
            end
            EN_GRANT: begin
                if (!act[q.ch])   d.state = EN_IDLE;
                else if (bus_gnt) d.state = EN_READ;
            end
            EN_READ: if (bus_ready) begin
                if (bus_err) d.state = EN_IDLE;
                else begin
                    d.hold  = bus_rdata;
                    d.state = EN_WRITE;
                end
            end
            default: if (bus_ready) begin
                if (!bus_err) d.last = q.ch;
                if (!bus_err && cfg_a[q.ch].burst && act[q.ch] && !lastb[q.ch]) d.state = EN_READ;
                else d.state = EN_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: EN_IDLE, ch: 1'b0, last: 1'b1, hold: '0};
        else        q <= d;
    end

    always_comb begin
        reg_rdata = rd_a[reg_addr[2]];
        bus_req   = (q.state != EN_IDLE);
        bus_valid = (q.state == EN_READ) || (q.state == EN_WRITE);
        bus_write = (q.state == EN_WRITE);
        bus_addr  = bus_write ? dst_a[q.ch] : src_a[q.ch];
        bus_size  = cfg_a[q.ch].size;
        bus_wdata = q.hold;
    end

    // R5: fixed order serves channel 0 when both request
    a_r5_fixed_order: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == EN_IDLE && creq == 2'b11 && !rr_mode) |=> (q.ch == 1'b0));

    // R6: rotation serves the channel not served last
    a_r6_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == EN_IDLE && creq == 2'b11 && rr_mode) |=> (q.ch != $past(q.last)));

    // R7: cycle steal releases the bus after each unit
    a_r7_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready && !bus_err && !cfg_a[q.ch].burst) |=> !bus_req);

    // R8: burst keeps the bus and goes straight to the next read
    a_r8_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_ready && !bus_err && cfg_a[q.ch].burst && act[q.ch] && !lastb[q.ch])
        |=> (bus_req && bus_valid && !bus_write));
endmodule

// File: tb/dma2_top_bench.sv
module dma2_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rr_mode = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ext_req = '0;
    logic [1:0]  irq;
    logic        bus_req, bus_valid, bus_write;
    logic        bus_gnt = 1'b0, bus_ready = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic [1:0]  bus_size;

    int checks = 0, errors = 0;
    int rises = 0, falls = 0, wcount = 0;
    logic [31:0] wlog [16];
    logic [7:0]  mem [256];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        prev_req = 1'b0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    dma2_top u_dma2_top (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // bus slave, grant and monitor
    always @(posedge clk) begin
        cyc <= cyc + 1;
        bus_gnt <= bus_req;
        bus_ready <= bus_valid && !bus_ready;
        bus_err <= bus_valid && !bus_ready && (bus_addr == err_addr);
        bus_rdata <= {mem[8'(bus_addr + 3)], mem[8'(bus_addr + 2)], mem[8'(bus_addr + 1)], mem[bus_addr[7:0]]};
        if (bus_valid && bus_write && bus_ready && !bus_err) begin
            mem[bus_addr[7:0]] <= bus_wdata[7:0];
            if (bus_size != 2'd0) mem[8'(bus_addr + 1)] <= bus_wdata[15:8];
            if (bus_size == 2'd2) begin
                mem[8'(bus_addr + 2)] <= bus_wdata[23:16];
                mem[8'(bus_addr + 3)] <= bus_wdata[31:24];
            end
            wlog[wcount % 16] <= bus_addr;
            wcount <= wcount + 1;
        end
        prev_req <= bus_req;
        if (bus_req && !prev_req) rises <= rises + 1;
        if (!bus_req && prev_req) falls <= falls + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_end(input int ch);
        logic [31:0] v;
        for (int t = 0; t < 3000; t++) begin
            rd(3'(ch * 4 + 3), v);
            if (v[17] || v[16]) return;
        end
        chk("timeout", 32'd0, 32'd1);
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] dd, input logic [31:0] n);
        wr(3'(ch * 4 + 0), s);
        wr(3'(ch * 4 + 1), dd);
        wr(3'(ch * 4 + 2), n);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 bus_req", 32'(bus_req), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 0);
        end
    endtask

    task automatic t_word_steal;
        logic [31:0] v;
        int f0 = falls;
        setup(0, 32'h00, 32'h40, 4);
        wr(3'd3, 32'h109);
        wait_end(0);
        for (int i = 0; i < 16; i++) chk("R2 word data", 32'(mem[8'h40 + i]), 32'(pat(i)));
        rd(3'd0, v); chk("R2 src advance", v, 32'h10);
        rd(3'd1, v); chk("R2 dst advance", v, 32'h50);
        rd(3'd2, v); chk("R2 count end", v, 0);
        chk("R7 falls", 32'(falls - f0), 4);
        chk("R10 irq enabled", 32'(irq[0]), 1);
        wr(3'd3, 32'h1_0108);
        rd(3'd3, v); chk("R10 w1c done", 32'(v[16]), 0);
        chk("R10 irq cleared", 32'(irq[0]), 0);
    endtask

    task automatic t_byte_burst;
        logic [31:0] v;
        int f0 = falls;
        setup(0, 32'h20, 32'h60, 3);
        wr(3'd3, 32'h051);
        wait_end(0);
        for (int i = 0; i < 3; i++) chk("R3 fixed src byte", 32'(mem[8'h60 + i]), 32'(pat(32'h20)));
        rd(3'd0, v); chk("R3 src held", v, 32'h20);
        rd(3'd1, v); chk("R2 byte step", v, 32'h63);
        chk("R8 one release", 32'(falls - f0), 1);
        rd(3'd3, v); chk("R10 done masked", 32'(v[16]), 1);
        chk("R10 irq masked", 32'(irq[0]), 0);
        wr(3'd3, 32'h1_0000);
    endtask

    task automatic t_half_dsthold;
        logic [31:0] v;
        setup(0, 32'h30, 32'h70, 2);
        wr(3'd3, 32'h025);
        wait_end(0);
        chk("R3 dst held lo", 32'(mem[8'h70]), 32'(pat(32'h32)));
        chk("R3 dst held hi", 32'(mem[8'h71]), 32'(pat(32'h33)));
        rd(3'd1, v); chk("R3 dst held", v, 32'h70);
        rd(3'd0, v); chk("R2 half step", v, 32'h34);
        wr(3'd3, 32'h1_0000);
    endtask

    task automatic t_priority(input logic rr);
        logic [31:0] v;
        int w0;
        setup(0, 32'h00, 32'h80, 2);
        setup(1, 32'h10, 32'hC0, 2);
        @(negedge clk) rr_mode = rr;
        wr(3'd3, 32'h089);
        wr(3'd7, 32'h089);
        w0 = wcount;
        repeat (10) @(negedge clk);
        chk("R9 no beat without ext_req", 32'(wcount - w0), 0);
        chk("R9 no bus_req", 32'(bus_req), 0);
        rd(3'd3, v); chk("R13 active reads 1", 32'(v[0]), 1);
        @(negedge clk) ext_req = 2'b11;
        wait_end(0);
        wait_end(1);
        @(negedge clk) ext_req = 2'b00;
        if (!rr) begin
            chk("R5 first", wlog[w0 % 16], 32'h80);
            chk("R5 second", wlog[(w0 + 1) % 16], 32'h84);
            chk("R5 third", wlog[(w0 + 2) % 16], 32'hC0);
        end else begin
            chk("R6 first", wlog[w0 % 16], 32'h80);
            chk("R6 second", wlog[(w0 + 1) % 16], 32'hC0);
            chk("R6 third", wlog[(w0 + 2) % 16], 32'h84);
            chk("R6 fourth", wlog[(w0 + 3) % 16], 32'hC4);
        end
        wr(3'd3, 32'h1_0000);
        wr(3'd7, 32'h1_0000);
    endtask

    task automatic t_bus_error;
        logic [31:0] v;
        setup(0, 32'h00, 32'h40, 4);
        @(negedge clk) err_addr = 32'h44;
        wr(3'd3, 32'h109);
        wait_end(0);
        @(negedge clk) err_addr = 32'hFFFF_FFFF;
        rd(3'd3, v);
        chk("R11 err set", 32'(v[17]), 1);
        chk("R11 not done", 32'(v[16]), 0);
        chk("R11 stopped", 32'(v[0]), 0);
        rd(3'd2, v); chk("R11 unit not counted", v, 3);
        chk("R11 irq", 32'(irq[0]), 1);
        wr(3'd3, 32'h2_0108);
        rd(3'd3, v); chk("R11 w1c err", 32'(v[17]), 0);
    endtask

    task automatic t_misaligned;
        logic [31:0] v;
        int r0 = rises;
        setup(1, 32'h02, 32'hC0, 2);
        wr(3'd7, 32'h109);
        repeat (8) @(negedge clk);
        rd(3'd7, v);
        chk("R12 err on misaligned", 32'(v[17]), 1);
        chk("R12 not active", 32'(v[0]), 0);
        chk("R12 no bus_req", 32'(rises - r0), 0);
        chk("R12 irq", 32'(irq[1]), 1);
        wr(3'd7, 32'h2_0000);
        wr(3'd4, 32'h00);
        wr(3'd7, 32'h00D);
        repeat (8) @(negedge clk);
        rd(3'd7, v);
        chk("R12 err on size 3", 32'(v[17]), 1);
        chk("R12 no bus_req size 3", 32'(rises - r0), 0);
        wr(3'd7, 32'h2_0000);
    endtask

    task automatic t_full_count_abort;
        logic [31:0] v;
        int w0, w1;
        setup(0, 32'h00, 32'h40, 0);
        w0 = wcount;
        wr(3'd3, 32'h009);
        for (int t = 0; t < 100 && wcount < w0 + 2; t++) @(negedge clk);
        wr(3'd3, 32'h00A);
        repeat (20) @(negedge clk);
        rd(3'd2, v);
        chk("R4 count large", 32'(v >= 32'hFF00 && v <= 32'hFFFE), 1);
        w1 = wcount;
        repeat (20) @(negedge clk);
        chk("R13 no beats after abort", 32'(wcount - w1), 0);
        chk("R13 bus idle", 32'(bus_req), 0);
        rd(3'd3, v);
        chk("R13 inactive", 32'(v[0]), 0);
        chk("R13 no done", 32'(v[16]), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_steal();
        t_byte_burst();
        t_half_dsthold();
        t_priority(1'b0);
        t_priority(1'b1);
        t_bus_error();
        t_misaligned();
        t_full_count_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule